// File: doc/BRIEF.md
# Router power-gating controller

This block decides, for one router of a two-dimensional mesh network-on-chip, when the router's power can be switched off and when it must be switched back on. While the router is gated, a bypass path outside this block keeps injecting, forwarding and ejecting packets. A flit that shows up at a sleeping router is therefore not a reason to wake it.

The controller steps through four states: on, draining, off and waking. It moves from on to off only after a run of idle cycles. Once off, it stays off for at least the break-even time, because a shorter sleep costs more energy than it saves. Wake-up comes from the mesh column, not from single packets. Each router watches the occupancy of its bypass buffer and raises an overload request when that buffer stays full enough for several cycles. Logic outside this block ORs these requests into one column wake line and feeds that line back to every router in the column, so a whole column wakes together. After the power switches close, the router spends a fixed number of cycles restoring before it accepts flits again.

Top module: `rpg_ctrl`

## Requirements
- R1: After reset, `router_ready` is 1, `sleep_en` is 0 and `col_wake_req` is 0.
- R2: A cycle is idle when `flit_activity`, `buf_nonempty`, `col_wake_in` and the router's own overload request are all 0. `router_ready` falls after the first idle cycle is sampled. `sleep_en` rises on the clock edge that samples the 4th consecutive idle cycle.
- R3: While the router is on or draining, any non-idle cycle sends it back to the on state, with `router_ready` high after that edge, and the idle count starts again from zero. An active `col_wake_in` therefore keeps the router on.
- R4: While `sleep_en` is high, `flit_activity` and `buf_nonempty` have no effect, and `sleep_en` stays high.
- R5: Once `sleep_en` rises it stays high for at least 10 cycles. A wake request that arrives inside that window is stored, even if it goes away again, and `sleep_en` falls on the 10th edge after gating.
- R6: When the 10-cycle window has already passed, a wake request makes `sleep_en` fall on the edge that samples it.
- R7: After `sleep_en` falls, `router_ready` stays 0 for exactly 8 cycles and then rises. Wake requests and activity during those cycles have no effect.
- R8: `col_wake_req` rises on the edge that samples the 3rd consecutive cycle with `byp_occupancy` at or above 6. It falls on the edge that samples an occupancy below 6. A run of high occupancy that breaks early does not raise it.
- R9: The router's own overload request wakes it just as `col_wake_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flit_activity | input | 1 | A flit moved on a router port this cycle |
| buf_nonempty | input | 1 | At least one router input buffer holds a flit |
| byp_occupancy | input | 4 | Current fill level of the bypass buffer |
| col_wake_in | input | 1 | Column wake line: the OR of all overload requests in the column |
| col_wake_req | output | 1 | This router's overload request toward the column wake OR |
| sleep_en | output | 1 | Drives the power switches: 1 means the router is gated |
| router_ready | output | 1 | The router is powered and may accept flits |

## Verification
The in-module assertions check on every cycle the properties that hold at each step:
- gating only follows a full idle run that the idle monitor has counted;
- the router cannot leave the off state before the break-even counter is complete;
- a request seen while off is stored;
- the waking state lasts its full count;
- an overload request always follows a high-occupancy sample.

Other behaviours need whole scenarios, and only the bench can show them:
- the exact edges on which the outputs change;
- a request that arrives early and vanishes, yet still wakes the router at the break-even point;
- a drain cut short by a nonempty buffer or by the column line;
- an occupancy run that breaks one sample short of the limit.

// File: rtl/pg_pkg.sv
package pg_pkg;

   typedef enum logic [1:0] {
      PG_ON     = 2'd0,
      PG_DRAIN  = 2'd1,
      PG_OFF    = 2'd2,
      PG_WAKING = 2'd3
   } pg_state_e;

endpackage

// File: rtl/pg_overload_det.sv
module pg_overload_det #(
   parameter int OCC_W   = 4,
   parameter int THRESH  = 6,
   parameter int RUN_CYC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OCC_W-1:0] occ,
   output logic             overload
);

   localparam logic [OCC_W-1:0] TH_V = OCC_W'(THRESH);

   if (OCC_W < 1) begin : g_chk_w
      $error("pg_overload_det: OCC_W must be at least 1");
   end
   if (THRESH < 1 || THRESH >= (1 << OCC_W)) begin : g_chk_th
      $error("pg_overload_det: THRESH out of range for OCC_W");
   end
   if (RUN_CYC < 1) begin : g_chk_run
      $error("pg_overload_det: RUN_CYC must be at least 1");
   end

   logic occ_hi;
   assign occ_hi = (occ >= TH_V);

   if (RUN_CYC == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) overload <= 1'b0;
         else        overload <= occ_hi;
      end
   end else begin : g_count
      localparam int RW = $clog2(RUN_CYC + 1);
      localparam logic [RW-1:0] RUN_V = RW'(RUN_CYC);
      logic [RW-1:0] run_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              run_cnt <= '0;
         else if (!occ_hi)        run_cnt <= '0;
         else if (run_cnt != RUN_V) run_cnt <= run_cnt + RW'(1);
      end

      assign overload = (run_cnt == RUN_V);
   end

   // R8: a request is only present after a high-occupancy sample
   p_ovl_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      overload |-> $past(occ_hi));

endmodule

// File: rtl/pg_idle_mon.sv
module pg_idle_mon #(
   parameter int IDLE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic idle,
   output logic hit
);

   if (IDLE_CYC < 1) begin : g_chk_idle
      $error("pg_idle_mon: IDLE_CYC must be at least 1");
   end

   localparam int CW = $clog2(IDLE_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(IDLE_CYC - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!arm || !idle)  cnt <= '0;
      else if (cnt != LAST)    cnt <= cnt + CW'(1);
   end

   assign hit = arm && idle && (cnt == LAST);

   // R2, R3: a nonzero count means the previous cycle was idle while armed
   p_consec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && idle && cnt != '0) |-> ($past(idle) && $past(arm)));

endmodule

// File: rtl/pg_fsm.sv
module pg_fsm
   import pg_pkg::*;
#(
   parameter int BREAK_EVEN = 10,
   parameter int WAKE_CYC   = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      idle,
   input  logic      idle_hit,
   input  logic      wake_req,
   output pg_state_e state,
   output logic      sleep_en,
   output logic      router_ready
);

   if (BREAK_EVEN < 1) begin : g_chk_be
      $error("pg_fsm: BREAK_EVEN must be at least 1");
   end
   if (WAKE_CYC < 1) begin : g_chk_wk
      $error("pg_fsm: WAKE_CYC must be at least 1");
   end

   localparam int OW = $clog2(BREAK_EVEN + 1);
   localparam int WW = $clog2(WAKE_CYC + 1);
   localparam logic [OW-1:0] OFF_LAST  = OW'(BREAK_EVEN - 1);
   localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_CYC - 1);

   pg_state_e     state_nx;
   logic [OW-1:0] off_cnt;
   logic [WW-1:0] wake_cnt;
   logic          pending;

   always_comb begin
      state_nx = state;
      unique case (state)
         PG_ON:     if (idle) state_nx = idle_hit ? PG_OFF : PG_DRAIN;
         PG_DRAIN:  if (!idle) state_nx = PG_ON;
                    else if (idle_hit) state_nx = PG_OFF;
         PG_OFF:    if (off_cnt == OFF_LAST && (pending || wake_req))
                       state_nx = PG_WAKING;
         PG_WAKING: if (wake_cnt == WAKE_LAST) state_nx = PG_ON;
         default:   state_nx = PG_ON;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PG_ON;
      else        state <= state_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  off_cnt <= '0;
      else if (state != PG_OFF)    off_cnt <= '0;
      else if (off_cnt != OFF_LAST) off_cnt <= off_cnt + OW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      wake_cnt <= '0;
      else if (state != PG_WAKING)     wake_cnt <= '0;
      else if (wake_cnt != WAKE_LAST)  wake_cnt <= wake_cnt + WW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               pending <= 1'b0;
      else if (state != PG_OFF) pending <= 1'b0;
      else if (wake_req)        pending <= 1'b1;
   end

   assign sleep_en     = (state == PG_OFF);
   assign router_ready = (state == PG_ON);

   // R2: gating starts only when the idle monitor reports a full run
   p_gate_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_en) |-> $past(idle_hit));

   // R5: no exit from the off state before break-even
   p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PG_OFF && off_cnt != OFF_LAST) |=> state == PG_OFF);

   // R5: leaving the off state happens only at the final break-even count
   p_min_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep_en) |-> $past(off_cnt) == OFF_LAST);

   // R5: a request seen while off is kept until it is served
   p_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PG_OFF && wake_req) |=> (pending || state == PG_WAKING));

   // R7: waking runs its full count
   p_wake_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PG_WAKING && wake_cnt != WAKE_LAST) |=> state == PG_WAKING);

   // R7: ready returns after waking only once the count is complete
   p_wake_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(router_ready) && $past(state) == PG_WAKING)
         |-> $past(wake_cnt) == WAKE_LAST);

endmodule

// File: rtl/rpg_ctrl.sv
module rpg_ctrl
   import pg_pkg::*;
#(
   parameter int OCC_W      = 4,
   parameter int OVL_THRESH = 6,
   parameter int OVL_CYC    = 3,
   parameter int IDLE_CYC   = 4,
   parameter int BREAK_EVEN = 10,
   parameter int WAKE_CYC   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flit_activity,
   input  logic             buf_nonempty,
   input  logic [OCC_W-1:0] byp_occupancy,
   input  logic             col_wake_in,
   output logic             col_wake_req,
   output logic             sleep_en,
   output logic             router_ready
);

   pg_state_e state;
   logic      wake_req;
   logic      idle;
   logic      arm;
   logic      idle_hit;

   pg_overload_det #(
      .OCC_W   (OCC_W),
      .THRESH  (OVL_THRESH),
      .RUN_CYC (OVL_CYC)
   ) u_ovl (
      .clk      (clk),
      .rst_n    (rst_n),
      .occ      (byp_occupancy),
      .overload (col_wake_req)
   );

   // R9: column line and own overload both request a wake
   assign wake_req = col_wake_in | col_wake_req;
   assign idle     = !flit_activity && !buf_nonempty && !wake_req;
   assign arm      = (state == PG_ON) || (state == PG_DRAIN);

   pg_idle_mon #(
      .IDLE_CYC (IDLE_CYC)
   ) u_idle (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (arm),
      .idle  (idle),
      .hit   (idle_hit)
   );

   pg_fsm #(
      .BREAK_EVEN (BREAK_EVEN),
      .WAKE_CYC   (WAKE_CYC)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .idle         (idle),
      .idle_hit     (idle_hit),
      .wake_req     (wake_req),
      .state        (state),
      .sleep_en     (sleep_en),
      .router_ready (router_ready)
   );

   // R3: an active wake request while powered keeps the router out of gating
   p_wake_blocks_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && wake_req) |=> !sleep_en);

endmodule

// File: tb/tb_rpg_ctrl.sv
module tb_rpg_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 30;

   // row: {flit, bufne, colwake, occ[3:0], exp_sleep, exp_ready, exp_req}
   localparam logic [9:0] VEC [0:NV-1] = '{
      10'b1_0_0_0000_0_1_0,  // 0  busy, stays on
      10'b0_0_0_0000_0_0_0,  // 1  idle 1: draining
      10'b0_0_0_0000_0_0_0,  // 2  idle 2
      10'b0_0_0_0000_0_0_0,  // 3  idle 3
      10'b0_0_0_0000_1_0_0,  // 4  idle 4: gated
      10'b1_1_0_0000_1_0_0,  // 5  activity ignored while off
      10'b0_0_1_0000_1_0_0,  // 6  early wake request, latched
      10'b0_0_0_0000_1_0_0,  // 7
      10'b0_0_0_0000_1_0_0,  // 8
      10'b0_0_0_0000_1_0_0,  // 9
      10'b0_0_0_0000_1_0_0,  // 10
      10'b0_0_0_0000_1_0_0,  // 11
      10'b0_0_0_0000_1_0_0,  // 12
      10'b0_0_0_0000_1_0_0,  // 13 10th off cycle
      10'b0_0_0_0000_0_0_0,  // 14 break-even done: waking
      10'b0_0_0_0000_0_0_0,  // 15
      10'b0_0_1_0000_0_0_0,  // 16 request during waking ignored
      10'b1_1_0_0000_0_0_0,  // 17 activity during waking ignored
      10'b1_1_0_0000_0_0_0,  // 18
      10'b1_1_0_0000_0_0_0,  // 19
      10'b1_1_0_0000_0_0_0,  // 20
      10'b1_1_0_0000_0_0_0,  // 21
      10'b0_0_0_0000_0_1_0,  // 22 8 waking cycles done: ready
      10'b1_0_0_0000_0_1_0,  // 23
      10'b1_0_0_0110_0_1_0,  // 24 occupancy at threshold, run 1
      10'b1_0_0_0110_0_1_0,  // 25 run 2
      10'b1_0_0_0110_0_1_1,  // 26 run 3: overload
      10'b0_0_0_0110_0_1_1,  // 27 own overload keeps router on
      10'b0_0_0_0011_0_1_0,  // 28 occupancy drops: request falls
      10'b0_0_0_0011_0_0_0   // 29 now idle: draining
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       flit_activity = 1'b0;
   logic       buf_nonempty = 1'b0;
   logic [3:0] byp_occupancy = '0;
   logic       col_wake_in = 1'b0;
   logic       col_wake_req;
   logic       sleep_en;
   logic       router_ready;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rpg_ctrl dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .flit_activity (flit_activity),
      .buf_nonempty  (buf_nonempty),
      .byp_occupancy (byp_occupancy),
      .col_wake_in   (col_wake_in),
      .col_wake_req  (col_wake_req),
      .sleep_en      (sleep_en),
      .router_ready  (router_ready)
   );

   function automatic string row_req(int i);
      if (i <= 4)  return "R2";
      if (i == 5)  return "R4";
      if (i <= 14) return "R5";
      if (i <= 22) return "R7";
      return "R8";
   endfunction

   // compare {sleep_en, router_ready, col_wake_req}
   task automatic check(string req, logic [2:0] exp);
      logic [2:0] act;
      act = {sleep_en, router_ready, col_wake_req};
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {sleep,ready,req} actual %b expected %b at %0t",
                  req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic drive(logic f, logic b, logic c, logic [3:0] o);
      flit_activity = f;
      buf_nonempty  = b;
      col_wake_in   = c;
      byp_occupancy = o;
   endtask

   task automatic do_reset();
      drive(1'b0, 1'b0, 1'b0, 4'd0);
      rst_n = 1'b0;
      tick();
      tick();
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      do_reset();
      check("R1", 3'b010);

      // table walk
      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6:3]);
         tick();
         check(row_req(i), VEC[i][2:0]);
      end

      // R3: drain cut short by a nonempty buffer restarts the count
      do_reset();
      for (int k = 0; k < 3; k++) tick();
      check("R3", 3'b000);
      drive(1'b0, 1'b1, 1'b0, 4'd0);
      tick();
      check("R3", 3'b010);
      drive(1'b0, 1'b0, 1'b0, 4'd0);
      for (int k = 0; k < 3; k++) tick();
      check("R3", 3'b000);
      tick();
      check("R2", 3'b100);

      // R6, R9: long sleep, then own overload wakes at once
      for (int k = 0; k < 20; k++) tick();
      check("R4", 3'b100);
      drive(1'b0, 1'b0, 1'b0, 4'd6);
      tick();
      tick();
      check("R8", 3'b100);
      tick();
      check("R8", 3'b101);
      tick();
      check("R9", 3'b001);
      for (int k = 0; k < 7; k++) tick();
      check("R7", 3'b001);
      tick();
      check("R7", 3'b011);

      // R3: column wake held while on blocks gating
      do_reset();
      drive(1'b0, 1'b0, 1'b1, 4'd0);
      for (int k = 0; k < 8; k++) tick();
      check("R3", 3'b010);
      drive(1'b0, 1'b0, 1'b0, 4'd0);
      for (int k = 0; k < 4; k++) tick();
      check("R2", 3'b100);
      // R6: one-cycle column pulse after break-even
      for (int k = 0; k < 12; k++) tick();
      drive(1'b0, 1'b0, 1'b1, 4'd0);
      tick();
      check("R6", 3'b000);
      drive(1'b0, 1'b0, 1'b0, 4'd0);

      // R8: run broken by occupancy just below threshold
      do_reset();
      drive(1'b1, 1'b0, 1'b0, 4'd6);
      tick();
      tick();
      drive(1'b1, 1'b0, 1'b0, 4'd5);
      tick();
      check("R8", 3'b010);
      drive(1'b1, 1'b0, 1'b0, 4'd15);
      tick();
      tick();
      check("R8", 3'b010);
      tick();
      check("R8", 3'b011);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule